// File: doc/BRIEF.md
# Quasi-Cyclic LDPC Systematic Encoder (rate 1/2, 648-bit codeword)

This block turns a 324-bit message into a 648-bit codeword of a quasi-cyclic low-density parity-check code of rate 1/2. The code's parity-check matrix H has 12 block rows and 24 block columns. Each block is a 27x27 circulant, which is either all-zero or a shifted identity. The encoder splits H into a lower-triangular gap form with a gap of one block row. It forms the parity in four steps, with a register after each step. The steps are: the message products, the gap projection through the inverse of the triangular part, the first parity block p1, and the back-substituted remaining parity p2.

Every product against a fixed matrix is an XOR network. The network is fixed at elaboration from a shift table that is computed at elaboration time. No memory, table ROM or run-time rotator is built. A new message can enter on every clock, and each result leaves a fixed number of cycles later with its own valid strobe.

Top module: `qcl_enc`

## Requirements
- R1: The codeword has three parts. Bits 323:0 are the message unchanged. Bits 350:324 are p1. Bits 647:351 are p2. Block j of the codeword holds bits j*27+26 down to j*27.
- R2: Each output codeword x satisfies H·x = 0 over GF(2), with H defined by the rules below.
  - How a block acts on a 27-bit sub-word v: a block with shift k produces output bit i = v[(i+k) mod 27], and an empty block produces zero.
  - Message columns c = 0..11, row r: the block is present when (r+2c) mod 3 = 0, and its shift is (7r+13c+3) mod 27.
  - Column 12: rows 0 and 10 have shift 1, row 5 has shift 0, and all other rows are empty.
  - Column 13+j for j = 0..10: rows j and j+1 have shift 0, and all other rows are empty.
- R3: With the default configuration (all four step registers present), a message sampled with msg_vld high at clock edge n appears with cw_vld high right after edge n+3.
- R4: Messages presented on consecutive cycles are each encoded independently. Their codewords leave on consecutive cycles in arrival order.
- R5: While rst_n is low at a clock edge, cw_vld is low after that edge. Messages in flight when reset is applied never appear at the output.
- R6: An all-zero message gives an all-zero codeword.
- R7: The encoder is linear. The codeword of the XOR of two messages equals the XOR of their two codewords.
- R8: A cycle without msg_vld produces a cycle with cw_vld low, at the same latency as R3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset of the valid flags |
| msg_vld | input | 1 | Message strobe |
| msg | input | 324 | Message word |
| cw_vld | output | 1 | Codeword strobe |
| cw | output | 648 | Codeword: message, then p1, then p2 |

## Verification
Two events can fall in the same cycle: a new message being accepted and an earlier codeword leaving. The bench provokes this by streaming all 324 single-bit messages back to back, so the pipeline is full in every cycle. Each output is judged by the full syndrome, the systematic part and its slot in the timing. Reset landing on a full pipeline is the second overlap. The bench fires reset while three messages are in flight and requires that none of them emerges, and that the next message after reset is encoded cleanly.

// File: rtl/qcl_pkg.sv
package qcl_pkg;

   // Shift of the message-side block (row r, column c); -1 means empty block.
   function automatic int msg_shift(input int r, input int c, input int z);
      if (((r + 2 * c) % 3) == 0) return (7 * r + 13 * c + 3) % z;
      return -1;
   endfunction

   // Shift of the p1-column block in top row r (ntop top rows); -1 means empty.
   // Two shift-1 blocks plus one identity sum to the identity, so the gap
   // matrix reduces to I and p1 needs no inverse network.
   function automatic int p1_shift(input int r, input int ntop);
      if (r == 0 || r == ntop - 1) return 1;
      if (r == (ntop - 1) / 2) return 0;
      return -1;
   endfunction

endpackage

// File: rtl/qcl_block_row.sv
module qcl_block_row #(
   parameter int Z    = 27,
   parameter int NCOL = 12,
   parameter int ROW  = 0
) (
   input  logic [NCOL*Z-1:0] vec,
   output logic [Z-1:0]      sum
);
   logic [NCOL-1:0][Z-1:0] term;

   for (genvar c = 0; c < NCOL; c++) begin : g_col
      localparam int SH = qcl_pkg::msg_shift(ROW, c, Z);
      if (SH >= 0) begin : g_nz
         for (genvar i = 0; i < Z; i++) begin : g_bit
            assign term[c][i] = vec[c*Z + ((i + SH) % Z)];
         end
      end else begin : g_z
         assign term[c] = '0;
      end
   end

   always_comb begin
      sum = '0;
      for (int c = 0; c < NCOL; c++) sum ^= term[c];
   end
endmodule

// File: rtl/qcl_chain_solve.sv
module qcl_chain_solve #(
   parameter int Z  = 27,
   parameter int NB = 11
) (
   input  logic [NB*Z-1:0] rhs,
   output logic [NB*Z-1:0] sol
);
   // T is identity on the diagonal and the sub-diagonal: back substitution
   // is a running XOR down the block rows.
   logic [Z-1:0] run;
   always_comb begin
      run = '0;
      sol = '0;
      for (int b = 0; b < NB; b++) begin
         run = run ^ rhs[b*Z +: Z];
         sol[b*Z +: Z] = run;
      end
   end
endmodule

// File: rtl/qcl_stage.sv
module qcl_stage #(
   parameter int W  = 8,
   parameter bit EN = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         i_vld,
   input  logic [W-1:0] i_dat,
   output logic         o_vld,
   output logic [W-1:0] o_dat
);
   if (EN) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) o_vld <= 1'b0;
         else        o_vld <= i_vld;
      end
      always_ff @(posedge clk) begin
         if (i_vld) o_dat <= i_dat;
      end
   end else begin : g_wire
      assign o_vld = i_vld;
      assign o_dat = i_dat;
   end
endmodule

// File: rtl/qcl_enc.sv
module qcl_enc #(
   parameter int       Z         = 27,
   parameter int       KB        = 12,
   parameter bit [3:0] PIPE_MASK = 4'b1111
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              msg_vld,
   input  logic [KB*Z-1:0]   msg,
   output logic              cw_vld,
   output logic [2*KB*Z-1:0] cw
);
   localparam int K   = KB * Z;
   localparam int N   = 2 * K;
   localparam int TB  = KB - 1;
   localparam int TW  = TB * Z;
   localparam int W1  = K + TW + Z;
   localparam int W2  = K + TW + 2 * Z;
   localparam int W3  = K + TW + Z;
   localparam int LAT = int'(PIPE_MASK[0]) + int'(PIPE_MASK[1])
                      + int'(PIPE_MASK[2]) + int'(PIPE_MASK[3]);

   if (Z < 2)  begin : g_bad_z  $error("qcl_enc: Z must be at least 2");  end
   if (KB < 4) begin : g_bad_kb $error("qcl_enc: KB must be at least 4"); end

   // Step 1: A*s (top rows) and C*s (gap row)
   logic [TW-1:0] s1_a;
   logic [Z-1:0]  s1_c;
   for (genvar r = 0; r < TB; r++) begin : g_arow
      qcl_block_row #(.Z(Z), .NCOL(KB), .ROW(r)) u_row (
         .vec(msg), .sum(s1_a[r*Z +: Z]));
   end
   qcl_block_row #(.Z(Z), .NCOL(KB), .ROW(TB)) u_crow (
      .vec(msg), .sum(s1_c));

   logic          q1_vld;
   logic [W1-1:0] q1;
   qcl_stage #(.W(W1), .EN(PIPE_MASK[0])) u_st1 (
      .clk(clk), .rst_n(rst_n), .i_vld(msg_vld), .i_dat({msg, s1_a, s1_c}),
      .o_vld(q1_vld), .o_dat(q1));

   // Step 2: E*T^-1*(A*s); E selects the last row of T^-1, the sum of all blocks
   logic [K-1:0]  r1_m;
   logic [TW-1:0] r1_a;
   logic [Z-1:0]  r1_c;
   logic [Z-1:0]  s2_e;
   assign {r1_m, r1_a, r1_c} = q1;
   always_comb begin
      s2_e = '0;
      for (int b = 0; b < TB; b++) s2_e ^= r1_a[b*Z +: Z];
   end

   logic          q2_vld;
   logic [W2-1:0] q2;
   qcl_stage #(.W(W2), .EN(PIPE_MASK[1])) u_st2 (
      .clk(clk), .rst_n(rst_n), .i_vld(q1_vld), .i_dat({r1_m, r1_a, r1_c, s2_e}),
      .o_vld(q2_vld), .o_dat(q2));

   // Step 3: p1 = E*T^-1*A*s + C*s (gap matrix is identity)
   logic [K-1:0]  r2_m;
   logic [TW-1:0] r2_a;
   logic [Z-1:0]  r2_c;
   logic [Z-1:0]  r2_e;
   assign {r2_m, r2_a, r2_c, r2_e} = q2;

   logic          q3_vld;
   logic [W3-1:0] q3;
   qcl_stage #(.W(W3), .EN(PIPE_MASK[2])) u_st3 (
      .clk(clk), .rst_n(rst_n), .i_vld(q2_vld), .i_dat({r2_m, r2_a, r2_c ^ r2_e}),
      .o_vld(q3_vld), .o_dat(q3));

   // Step 4: p2 = T^-1*(A*s + B*p1)
   logic [K-1:0]  r3_m;
   logic [TW-1:0] r3_a;
   logic [Z-1:0]  r3_p1;
   logic [TW-1:0] s4_bp;
   logic [TW-1:0] s4_p2;
   assign {r3_m, r3_a, r3_p1} = q3;
   for (genvar b = 0; b < TB; b++) begin : g_bcol
      localparam int SH = qcl_pkg::p1_shift(b, TB);
      if (SH >= 0) begin : g_nz
         for (genvar i = 0; i < Z; i++) begin : g_bit
            assign s4_bp[b*Z + i] = r3_a[b*Z + i] ^ r3_p1[(i + SH) % Z];
         end
      end else begin : g_z
         assign s4_bp[b*Z +: Z] = r3_a[b*Z +: Z];
      end
   end
   qcl_chain_solve #(.Z(Z), .NB(TB)) u_solve (.rhs(s4_bp), .sol(s4_p2));

   qcl_stage #(.W(N), .EN(PIPE_MASK[3])) u_st4 (
      .clk(clk), .rst_n(rst_n), .i_vld(q3_vld), .i_dat({s4_p2, r3_p1, r3_m}),
      .o_vld(cw_vld), .o_dat(cw));

   if (LAT > 0) begin : g_chk
      // R3
      lat_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
         msg_vld |-> ##LAT cw_vld);
      // R1
      sys_part_chk: assert property (@(posedge clk) disable iff (!rst_n)
         cw_vld |-> cw[K-1:0] == $past(msg, LAT));
      // R2
      gap_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
         cw_vld |-> cw[N-1 -: Z] == $past(s1_c, LAT));
      // R2
      top_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
         cw_vld |-> cw[K+Z +: Z] == ($past(s1_a[Z-1:0], LAT) ^ {cw[K], cw[K+Z-1:K+1]}));
      // R5
      rst_clear_chk: assert property (@(posedge clk)
         !rst_n |=> !cw_vld);
   end
endmodule

// File: tb/qcl_enc_tb.sv
`timescale 1ns/1ps
module qcl_enc_tb;
   localparam int Z  = 27;
   localparam int KB = 12;
   localparam int K  = KB * Z;
   localparam int N  = 2 * K;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         msg_vld = 1'b0;
   logic [K-1:0] msg = '0;
   logic         cw_vld;
   logic [N-1:0] cw;

   qcl_enc u_dut (.clk(clk), .rst_n(rst_n), .msg_vld(msg_vld), .msg(msg),
                  .cw_vld(cw_vld), .cw(cw));

   always #2 clk = ~clk;

   int n_chk = 0;
   int n_fail = 0;
   int pc = 0;
   bit done = 1'b0;

   logic         ring_v [8];
   logic         ring_r [8];
   logic [K-1:0] ring_m [8];
   logic [N-1:0] out_log [512];
   int           n_out = 0;
   int           n_sent = 0;

   initial for (int i = 0; i < 8; i++) begin
      ring_v[i] = 1'b0; ring_r[i] = 1'b0; ring_m[i] = '0;
   end

   always @(posedge clk) pc <= pc + 1;

   task automatic check(input bit ok, input string req, input string what,
                        input logic [N-1:0] act, input logic [N-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // Block action from R2: out bit i = v[(i+k) mod 27]
   function automatic logic [Z-1:0] blk(input logic [Z-1:0] v, input int k);
      logic [Z-1:0] o;
      for (int i = 0; i < Z; i++) o[i] = v[(i + k) % Z];
      return o;
   endfunction

   function automatic int entry(input int r, input int c);
      if (c < KB) return (((r + 2 * c) % 3) == 0) ? (7 * r + 13 * c + 3) % Z : -1;
      if (c == KB) return (r == 0 || r == 10) ? 1 : (r == 5 ? 0 : -1);
      return (r == c - KB - 1 || r == c - KB) ? 0 : -1;
   endfunction

   function automatic logic [Z-1:0] syndrome_or(input logic [N-1:0] x);
      logic [Z-1:0] tot = '0;
      for (int r = 0; r < KB; r++) begin
         logic [Z-1:0] acc = '0;
         for (int c = 0; c < 2 * KB; c++) begin
            int k = entry(r, c);
            if (k >= 0) acc ^= blk(x[c*Z +: Z], k);
         end
         tot |= acc;
      end
      return tot;
   endfunction

   // Monitor, sampling away from the rising edge
   always @(negedge clk) begin
      logic         ev;
      logic [K-1:0] em;
      ev = 1'b0;
      em = '0;
      if (pc >= 4) begin
         ev = ring_v[(pc - 4) % 8];
         em = ring_m[(pc - 4) % 8];
         for (int d = 1; d <= 4; d++) ev = ev & ring_r[(pc - d) % 8];
      end
      // R3 R5 R8: valid strobe timing
      check(cw_vld === ev, "R3/R5/R8", "cw_vld", N'(cw_vld), N'(ev));
      if (ev && cw_vld === 1'b1) begin
         check(cw[K-1:0] === em, "R1", "systematic part", N'(cw[K-1:0]), N'(em));
         check(syndrome_or(cw) === '0, "R2", "syndrome", N'(syndrome_or(cw)), '0);
         if (em == '0) check(cw === '0, "R6", "zero codeword", cw, '0);
         if (n_out < 512) out_log[n_out] = cw;
         n_out++;
      end
   end

   task automatic step(input logic r, input logic v, input logic [K-1:0] m);
      @(posedge clk);
      #1;
      rst_n = r; msg_vld = v; msg = m;
      ring_r[pc % 8] = r; ring_v[pc % 8] = v; ring_m[pc % 8] = m;
      if (r && v) n_sent++;
   endtask

   function automatic logic [K-1:0] rnd_msg();
      logic [K-1:0] m;
      for (int i = 0; i < K; i++) m[i] = 1'($urandom_range(0, 1));
      return m;
   endfunction

   initial begin
      int lin_idx;
      logic [K-1:0] ma, mb;
      // R5: reset state
      repeat (5) step(1'b0, 1'b0, '0);
      // R6 and all-ones
      step(1'b1, 1'b1, '0);
      step(1'b1, 1'b1, '1);
      step(1'b1, 1'b0, '0);
      // R4: every single-bit message, back to back
      for (int b = 0; b < K; b++) step(1'b1, 1'b1, K'(1) << b);
      // R8: random messages with gaps
      for (int i = 0; i < 40; i++) begin
         step(1'b1, 1'b1, rnd_msg());
         if (($urandom % 3) == 0) step(1'b1, 1'b0, rnd_msg());
      end
      repeat (6) step(1'b1, 1'b0, '0);
      // R7: linearity
      lin_idx = n_sent;
      ma = rnd_msg(); mb = rnd_msg();
      step(1'b1, 1'b1, ma);
      step(1'b1, 1'b1, mb);
      step(1'b1, 1'b1, ma ^ mb);
      repeat (6) step(1'b1, 1'b0, '0);
      check(n_out == n_sent, "R4", "codeword count", N'(n_out), N'(n_sent));
      if (lin_idx + 2 < 512)
         check((out_log[lin_idx] ^ out_log[lin_idx+1]) === out_log[lin_idx+2], "R7",
               "linearity", out_log[lin_idx] ^ out_log[lin_idx+1], out_log[lin_idx+2]);
      // R5: reset with messages in flight
      for (int i = 0; i < 3; i++) step(1'b1, 1'b1, rnd_msg());
      n_sent -= 3;
      step(1'b0, 1'b0, '0);
      step(1'b0, 1'b0, '0);
      for (int i = 0; i < 2; i++) step(1'b1, 1'b1, rnd_msg());
      repeat (8) step(1'b1, 1'b0, '0);
      check(n_out == n_sent, "R5", "flushed messages dropped", N'(n_out), N'(n_sent));
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog R3 actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule